// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Poller

This block sits next to an 8-bit controller core whose instructions take one to four clocks and fetch one byte per clock. It holds one request flag for each of six interrupt sources: two external pins, two timers, the serial port and the SPI unit. At the instruction boundary it decides whether the core jumps to a handler, and which handler.

The core raises `lastCycle` during the final clock of every instruction. In that clock the block reads the flags that were registered on the previous clock edge. It applies the enables, the two-level priority and the nesting state, then either stays silent or gives a one-clock take strobe with a handler address. With the strobe it gives a one-hot acknowledge that names the chosen source.

The external pins are sampled on every clock edge. Stack handling, return-from-interrupt tracking and opcode decoding belong to the core. The core reports the level of the handler currently running on the two-bit `inService` input.

Top module: `irqPollUnit`

## Requirements
- R1: After reset release, all flags are clear. A poll with every source enabled produces no take.
- R2: `takeIrq` is high only in a clock where `lastCycle` is high, and for that one clock only. The poll uses only flags registered on an earlier clock edge, so a request arriving in the poll clock itself is not taken in that poll.
- R3: With `extEdgeMode[i]=1`, a 1-to-0 change of `extPinN[i]` between two consecutive clock samples sets a flag. The flag stays set after the pin returns high. It is cleared by the acknowledge for that source.
- R4: With `extEdgeMode[i]=0`, the flag equals the inverted pin value sampled on the last clock edge. An acknowledge does not clear it, so a pin held low is taken at every poll.
- R5: A high `periphReq` bit sets its flag on the next edge. The bits are: bit0 timer 0, bit1 timer 1, bit2 serial, bit3 SPI. The flag is cleared by its acknowledge, and a new request in that same clock wins over the clear.
- R6: Source slots and handler addresses are: slot0 pin 0 → 0x0003, slot1 timer 0 → 0x000B, slot2 pin 1 → 0x0013, slot3 timer 1 → 0x001B, slot4 serial → 0x0023, slot5 SPI → 0x004B. `vectorAddr` is 0 when there is no take.
- R7: Among pending sources of the same priority, the lowest slot number is taken first.
- R8: A pending source with its `srcPriority` bit set wins over any pending source with the bit clear, whatever their slot numbers.
- R9: A source whose `srcEnable` bit is clear is never taken. Nothing is taken while `globalEnable` is low. A pending flag survives the masking and is taken once it is enabled again.
- R10: `inService` bit0 means a low-level handler is running and bit1 means a high-level handler is running. With bit1 set, nothing is taken. With only bit0 set, only high-priority sources are taken.
- R11: `flagAck` has at most one bit set. It is nonzero exactly when `takeIrq` is high, and its set bit is the slot of the handler address given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPinN | input | 2 | External request pins, active low (bit0 pin 0, bit1 pin 1) |
| extEdgeMode | input | 2 | Per pin: 1 falling-edge latch, 0 level |
| periphReq | input | 4 | Peripheral request pulses (timer 0, timer 1, serial, SPI) |
| srcEnable | input | 6 | Per-slot enable |
| globalEnable | input | 1 | Master enable |
| srcPriority | input | 6 | Per-slot priority, 1 = high |
| lastCycle | input | 1 | Final clock of the current instruction |
| inService | input | 2 | Level of handler in progress (bit0 low, bit1 high) |
| takeIrq | output | 1 | Take-interrupt strobe |
| vectorAddr | output | 16 | Handler address of the taken source |
| flagAck | output | 6 | One-hot acknowledge of the taken slot |

## Verification
The embedded properties check in every clock that the take falls only inside the final instruction clock with the master enable set, that the acknowledge is one-hot and matches the take, that a take always points at a flagged and enabled source, and that the nesting limits hold. The properties also check that an acknowledged edge or pulse flag is gone on the next clock. The bench's scenarios show what a property cannot see alone: the one-clock latency from request to poll eligibility, the sticky edge flag against the re-arming level flag, the exact handler addresses, and the order in which several pending sources drain.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC    = 6;
  localparam int NUM_EXT    = 2;
  localparam int NUM_PERIPH = 4;
  localparam int VEC_W      = 16;
  localparam int SPI_SLOT   = 5;

  typedef struct packed {
    logic               take;
    logic [NUM_SRC-1:0] ack;
  } pollStrobe_t;

  // slot of external pin i
  function automatic int extSlot(input int i);
    return 2 * i;
  endfunction

  // slot of peripheral request j: timers interleave with pins, rest follow
  function automatic int periphSlot(input int j);
    return (j < 2) ? (2 * j + 1) : (j + 2);
  endfunction

  function automatic logic [VEC_W-1:0] vecOf(input int slot);
    if (slot == SPI_SLOT) return VEC_W'(16'h004B);
    return VEC_W'(3 + slot * 8);
  endfunction

  function automatic logic [NUM_SRC-1:0] lowestSet(input logic [NUM_SRC-1:0] v);
    return v & (~v + NUM_SRC'(1));
  endfunction
endpackage

// File: rtl/irqFlagPath.sv
module irqFlagPath
  import irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EXT-1:0]    extPinN,
  input  logic [NUM_EXT-1:0]    extEdgeMode,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  pollStrobe_t           strobe,
  output logic [NUM_SRC-1:0]    flags
);

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    localparam int S = extSlot(i);
    logic pinPrev;
    logic flagQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pinPrev <= 1'b1;
        flagQ   <= 1'b0;
      end else begin
        pinPrev <= extPinN[i];
        if (extEdgeMode[i])
          flagQ <= (flagQ & ~strobe.ack[S]) | (pinPrev & ~extPinN[i]);
        else
          flagQ <= ~extPinN[i];
      end
    end
    assign flags[S] = flagQ;

    // R3: acknowledged edge flag with no new edge is gone next clock
    p_edge_ack_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
      (extEdgeMode[i] && strobe.ack[S] && extPinN[i]) |=> !flags[S]);
  end

  for (genvar j = 0; j < NUM_PERIPH; j++) begin : g_per
    localparam int S = periphSlot(j);
    logic flagQ;
    always_ff @(posedge clk) begin
      if (!rstN) flagQ <= 1'b0;
      else       flagQ <= (flagQ & ~strobe.ack[S]) | periphReq[j];
    end
    assign flags[S] = flagQ;

    // R5: acknowledged pulse flag with no new pulse is gone next clock
    p_pulse_ack_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.ack[S] && !periphReq[j]) |=> !flags[S]);
  end

endmodule

// File: rtl/irqPollCtrl.sv
module irqPollCtrl
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic               globalEnable,
  input  logic [NUM_SRC-1:0] srcPriority,
  input  logic               lastCycle,
  input  logic [1:0]         inService,
  output pollStrobe_t        strobe,
  output logic [VEC_W-1:0]   vectorAddr
);

  logic [NUM_SRC-1:0] pending, hiReq, loReq, grant;
  logic hiOk, loOk;

  always_comb begin
    pending = flags & srcEnable & {NUM_SRC{globalEnable}};
    hiReq   = pending & srcPriority;
    loReq   = pending & ~srcPriority;
    hiOk    = !inService[1];
    loOk    = (inService == 2'b00);
    if (hiOk && (|hiReq)) grant = lowestSet(hiReq);
    else if (loOk)        grant = lowestSet(loReq);
    else                  grant = '0;
    strobe.take = lastCycle && (|grant);
    strobe.ack  = lastCycle ? grant : '0;
  end

  always_comb begin
    vectorAddr = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (strobe.ack[i]) vectorAddr = vecOf(i);
  end

  // R2: a take happens only in the final instruction clock with master enable
  p_take_in_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> (lastCycle && globalEnable));

  // R11: acknowledge is one-hot and agrees with the take
  p_ack_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.ack) && (strobe.take == (|strobe.ack)));

  // R9: the taken slot is flagged and enabled
  p_take_flagged_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |-> (|(strobe.ack & flags & srcEnable)));

  // R10: nothing while a high handler runs
  p_nest_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    inService[1] |-> !strobe.take);

  // R10: only high-priority preempts a low handler
  p_nest_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inService[0] && strobe.take) |-> (|(strobe.ack & srcPriority)));

endmodule

// File: rtl/irqPollUnit.sv
module irqPollUnit
  import irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_EXT-1:0]    extPinN,
  input  logic [NUM_EXT-1:0]    extEdgeMode,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_SRC-1:0]    srcEnable,
  input  logic                  globalEnable,
  input  logic [NUM_SRC-1:0]    srcPriority,
  input  logic                  lastCycle,
  input  logic [1:0]            inService,
  output logic                  takeIrq,
  output logic [VEC_W-1:0]      vectorAddr,
  output logic [NUM_SRC-1:0]    flagAck
);

  pollStrobe_t        strobe;
  logic [NUM_SRC-1:0] flags;

  irqFlagPath u_path (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .extEdgeMode(extEdgeMode),
    .periphReq(periphReq), .strobe(strobe), .flags(flags)
  );

  irqPollCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .flags(flags), .srcEnable(srcEnable),
    .globalEnable(globalEnable), .srcPriority(srcPriority),
    .lastCycle(lastCycle), .inService(inService),
    .strobe(strobe), .vectorAddr(vectorAddr)
  );

  assign takeIrq = strobe.take;
  assign flagAck = strobe.ack;

endmodule

// File: tb/sim_irqPollUnit.sv
`timescale 1ns/1ps
module sim_irqPollUnit;
  logic clk = 1'b0;
  logic rstN;
  logic [1:0]  pinN, edgeMode, inSvc;
  logic [3:0]  periph;
  logic [5:0]  en, prio, ack;
  logic        gEn, last, take;
  logic [15:0] vec;

  int checks = 0;
  int fails  = 0;
  logic [5:0]  mFlags;
  logic [1:0]  mPrev;
  logic        obsTake;
  logic [15:0] obsVec;

  always #2.5 clk = ~clk;

  irqPollUnit u0 (
    .clk(clk), .rstN(rstN), .extPinN(pinN), .extEdgeMode(edgeMode),
    .periphReq(periph), .srcEnable(en), .globalEnable(gEn),
    .srcPriority(prio), .lastCycle(last), .inService(inSvc),
    .takeIrq(take), .vectorAddr(vec), .flagAck(ack)
  );

  function automatic logic [5:0] firstOf(input logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return 6'(1) << i;
    return 6'd0;
  endfunction

  // expected grant from the requirements (R7, R8, R9, R10)
  function automatic logic [5:0] expGrant();
    logic [5:0] p, hi, lo;
    if (!last || !gEn) return 6'd0;
    p  = mFlags & en;
    hi = p & prio;
    lo = p & ~prio;
    if (inSvc[1]) return 6'd0;
    if (hi != 0) return firstOf(hi);
    if (inSvc[0]) return 6'd0;
    return firstOf(lo);
  endfunction

  // address table from R6
  function automatic logic [15:0] expVec(input logic [5:0] g);
    case (g)
      6'b000001: return 16'h0003;
      6'b000010: return 16'h000B;
      6'b000100: return 16'h0013;
      6'b001000: return 16'h001B;
      6'b010000: return 16'h0023;
      6'b100000: return 16'h004B;
      default:   return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called after a negedge with inputs set; checks, then advances one clock
  task automatic tick();
    logic [5:0] g;
    #1;
    g = expGrant();
    chk("R2 take strobe", 16'(take), 16'(|g));
    chk("R6 vector", vec, expVec(g));
    chk("R11 ack", 16'(ack), 16'(g));
    obsTake = take;
    obsVec  = vec;
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      if (edgeMode[i]) mFlags[2*i] = (mFlags[2*i] & ~g[2*i]) | (mPrev[i] & ~pinN[i]);
      else             mFlags[2*i] = ~pinN[i];
    end
    mPrev = pinN;
    mFlags[1] = (mFlags[1] & ~g[1]) | periph[0];
    mFlags[3] = (mFlags[3] & ~g[3]) | periph[1];
    mFlags[4] = (mFlags[4] & ~g[4]) | periph[2];
    mFlags[5] = (mFlags[5] & ~g[5]) | periph[3];
    @(negedge clk);
  endtask

  task automatic idleInputs();
    pinN = 2'b11; edgeMode = 2'b11; periph = 4'd0; en = 6'h3F;
    gEn = 1'b1; prio = 6'd0; last = 1'b0; inSvc = 2'b00;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    idleInputs();
    rstN = 1'b0;
    mFlags = 6'd0; mPrev = 2'b11;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    last = 1'b1; tick();
    chk("R1 no take after reset", 16'(obsTake), 16'd0);
    last = 1'b0;

    // R2 / R5: request in poll clock is too late, taken at next poll
    periph = 4'b0001; last = 1'b1; tick();
    chk("R2 same-clock request not taken", 16'(obsTake), 16'd0);
    periph = 4'b0000; tick();
    chk("R5 timer0 taken next poll", obsVec, 16'h000B);
    last = 1'b0;

    // R3: sticky edge flag
    pinN = 2'b10; tick();
    pinN = 2'b11; tick(); tick();
    last = 1'b1; tick();
    chk("R3 edge flag held", obsVec, 16'h0003);
    tick();
    chk("R3 edge flag cleared by take", 16'(obsTake), 16'd0);
    last = 1'b0;

    // R4: level flag re-arms
    edgeMode = 2'b01; pinN = 2'b01; tick();
    last = 1'b1; tick();
    chk("R4 level taken", obsVec, 16'h0013);
    tick();
    chk("R4 level taken again", obsVec, 16'h0013);
    pinN = 2'b11; last = 1'b0; tick();
    last = 1'b1; tick();
    chk("R4 level released", 16'(obsTake), 16'd0);
    last = 1'b0; edgeMode = 2'b11;

    // R7: fixed order within a level
    periph = 4'b0101; tick();
    periph = 4'b0000; last = 1'b1; tick();
    chk("R7 lower slot first", obsVec, 16'h000B);
    tick();
    chk("R7 then serial", obsVec, 16'h0023);
    last = 1'b0;

    // R8: high priority beats lower slot
    prio = 6'b010000; pinN = 2'b10; periph = 4'b0100; tick();
    pinN = 2'b11; periph = 4'b0000; last = 1'b1; tick();
    chk("R8 high serial first", obsVec, 16'h0023);
    tick();
    chk("R8 then low pin0", obsVec, 16'h0003);
    last = 1'b0; prio = 6'd0;

    // R9: masking keeps the flag
    gEn = 1'b0; periph = 4'b1000; tick();
    periph = 4'b0000; last = 1'b1; tick();
    chk("R9 global off", 16'(obsTake), 16'd0);
    gEn = 1'b1; en = 6'h1F; tick();
    chk("R9 spi disabled", 16'(obsTake), 16'd0);
    en = 6'h3F; tick();
    chk("R9 spi after enable", obsVec, 16'h004B);
    last = 1'b0;

    // R10: nesting
    inSvc = 2'b01; prio = 6'b100000; periph = 4'b0001; tick();
    periph = 4'b0000; last = 1'b1; tick();
    chk("R10 low blocked under low", 16'(obsTake), 16'd0);
    last = 1'b0; periph = 4'b1000; tick();
    periph = 4'b0000; last = 1'b1; tick();
    chk("R10 high preempts low", obsVec, 16'h004B);
    inSvc = 2'b10; last = 1'b0; periph = 4'b1000; tick();
    periph = 4'b0000; last = 1'b1; tick();
    chk("R10 blocked under high", 16'(obsTake), 16'd0);
    inSvc = 2'b00; tick();
    chk("R10 release high first", obsVec, 16'h004B);
    tick();
    chk("R10 release low next", obsVec, 16'h000B);
    idleInputs(); tick();

    // random mix, model-checked each clock (R2 R3 R4 R5 R6 R7 R8 R9 R10 R11)
    for (int n = 0; n < 3000; n++) begin
      pinN     = 2'($urandom);
      if (($urandom % 16) == 0) edgeMode = 2'($urandom);
      periph   = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      en       = 6'($urandom) | 6'b101010;
      gEn      = ($urandom % 8) != 0;
      prio     = 6'($urandom);
      last     = ($urandom % 3) == 0;
      inSvc    = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      tick();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule